// File: doc/BRIEF.md
# Half-Duplex Serial Port with Driver Enable

This block is an asynchronous serial transmitter and receiver for a system-clocked design that talks to a half-duplex RS485 transceiver or to an ordinary point-to-point serial link. Bytes enter and leave through valid/ready handshakes. The transmitter puts each byte on the line as an NRZ frame. A driver-enable output goes high one bit period before the start bit, so the transceiver owns the bus while the line is still idle-high. It drops one bit period after the last stop bit.

The frame format and the bit rate are set at run time. A one-cycle configuration strobe loads the divisor, the word length, the parity selection, the stop-bit count and the flow-control switch together. Flow control follows the active-low request/clear-to-send convention. The receiver refuses new bytes by raising its request line while its single holding register is full. The transmitter waits for clear-to-send before it starts a frame, but it always finishes a frame it has begun.

The receiver counts in sixteenths of a bit and samples each bit at its middle. It reports parity and framing faults together with the byte they belong to.

Top module: `uart_rs485`

## Requirements
- R1: One bit period lasts 16 × D system clocks, where D is the configured divisor. A divisor of 0 acts as 1. At a 50 MHz clock, divisors from 3 to 10417 span about 1 Mbaud down to 300 baud.
- R2: A transmitted frame is made of the following parts, in order: one low start bit; 7 or 8 data bits, least significant bit first; an optional parity bit; one or two high stop bits. In 7-bit mode, data bit 7 is neither sent nor received, and a received 7-bit byte has bit 7 cleared.
- R3: With parity enabled, even selection makes the count of ones across the data bits and the parity bit even, and odd selection makes it odd. The receiver raises rx_perr with the byte when the received parity bit breaks this rule. rx_perr is 0 when parity is off.
- R4: tx_en rises on the clock edge that accepts a byte. It stays high for exactly one bit period of idle-high line before the start bit, for the whole frame, and for one further idle-high bit period after the last stop bit. It is low at all other times. txd is never low while tx_en is low.
- R5: tx_ready is high only while no frame is in progress and flow control allows a start. A byte is taken on a clock edge where tx_valid and tx_ready are both high.
- R6: With flow control enabled, cts_n high (seen through a two-flop synchroniser) holds tx_ready low, so no new frame starts. A frame already under way completes unchanged. With flow control disabled, cts_n has no effect.
- R7: With flow control enabled, rts_n is high exactly while the receive holding register is full (rx_valid high). With flow control disabled, rts_n stays low.
- R8: A received byte appears with rx_valid high and stays unchanged until the clock edge where rx_valid and rx_ready are both high. A frame that completes while the register is still full is discarded.
- R9: After a falling edge, the receiver checks the line eight sixteenths of a bit later. If the line is high again at that point, no byte results.
- R10: If the first stop bit is sampled low, rx_ferr is raised with the byte. The receiver then waits for the line to return high before it looks for a new start bit.
- R11: Reset loads the default configuration: divisor rounded from CLK_HZ/(16×9600) (326 at 50 MHz), 8 data bits, no parity, one stop bit, flow control on. A cfg_wr pulse replaces all of these fields at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Loads all configuration fields on this edge |
| cfg_div | input | DIV_W | Bit-period divisor D (bit = 16·D clocks) |
| cfg_len7 | input | 1 | 1 selects 7 data bits, 0 selects 8 |
| cfg_par_en | input | 1 | 1 adds a parity bit |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 even |
| cfg_stop2 | input | 1 | 1 sends two stop bits |
| cfg_fc_en | input | 1 | 1 enables request/clear-to-send flow control |
| tx_valid | input | 1 | Byte to send is offered |
| tx_data | input | 8 | Byte to send |
| tx_ready | output | 1 | Transmitter will accept a byte |
| rx_valid | output | 1 | Holding register contains a byte |
| rx_data | output | 8 | Received byte |
| rx_perr | output | 1 | Parity fault for the held byte |
| rx_ferr | output | 1 | Stop-bit fault for the held byte |
| rx_ready | input | 1 | Host takes the held byte |
| txd | output | 1 | Serial transmit line, idle high |
| rxd | input | 1 | Serial receive line, idle high |
| rts_n | output | 1 | Active-low request to send (high = hold off) |
| cts_n | input | 1 | Active-low clear to send |
| tx_en | output | 1 | Line driver enable for the transceiver |

## Verification
The most exposed edges are the two guard periods around each frame. A design that raised tx_en only at the start bit, or dropped it right after the stop bit, would cut off the first or last bit on a half-duplex bus, so the line and the enable are compared against a behavioural frame model on every clock. The bench also covers these mistakes:
- ignoring the second stop bit or the parity bit (odd and even), or sending data most significant bit first, which shifts or corrupts the frame;
- testing clear-to-send only once or stopping a running frame when it rises, which either sends against the far end or truncates bytes;
- losing a held byte to a later frame;
- decoding a short glitch as a start bit, which produces phantom bytes;
- re-arming on a low stop bit, which produces a second phantom byte after a framing fault.

// File: rtl/uart_rs485.sv
`timescale 1ns/1ps
module uart_rs485 #(
  parameter int CLK_HZ   = 50_000_000,
  parameter int DEF_BAUD = 9600,
  parameter int DIV_W    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic             cfg_len7,
  input  logic             cfg_par_en,
  input  logic             cfg_par_odd,
  input  logic             cfg_stop2,
  input  logic             cfg_fc_en,
  input  logic             tx_valid,
  input  logic [7:0]       tx_data,
  output logic             tx_ready,
  output logic             rx_valid,
  output logic [7:0]       rx_data,
  output logic             rx_perr,
  output logic             rx_ferr,
  input  logic             rx_ready,
  output logic             txd,
  input  logic             rxd,
  output logic             rts_n,
  input  logic             cts_n,
  output logic             tx_en
);
  localparam int CW      = DIV_W + 4;
  localparam int DEF_DIV = (CLK_HZ + 8 * DEF_BAUD) / (16 * DEF_BAUD);

  typedef enum logic [2:0] {T_IDLE, T_LEAD, T_START, T_DATA, T_PAR, T_STOP, T_TRAIL} tx_st_t;
  typedef enum logic [2:0] {R_IDLE, R_START, R_DATA, R_PAR, R_STOP, R_WAIT} rx_st_t;

  logic [DIV_W-1:0] div_q;
  logic len7_q, par_q, odd_q, stop2_q, fc_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      div_q   <= DIV_W'(DEF_DIV);
      len7_q  <= 1'b0;
      par_q   <= 1'b0;
      odd_q   <= 1'b0;
      stop2_q <= 1'b0;
      fc_q    <= 1'b1;
    end else if (cfg_wr) begin
      div_q   <= cfg_div;
      len7_q  <= cfg_len7;
      par_q   <= cfg_par_en;
      odd_q   <= cfg_par_odd;
      stop2_q <= cfg_stop2;
      fc_q    <= cfg_fc_en;
    end

  logic [DIV_W-1:0] div_eff;
  logic [CW-1:0]    bit_last;
  logic [2:0]       last_idx;
  assign div_eff  = (div_q == '0) ? DIV_W'(1) : div_q;
  assign bit_last = {div_eff, 4'b0000} - CW'(1);
  assign last_idx = len7_q ? 3'd6 : 3'd7;

  logic cts_m, cts_s, rx_m, rx_s;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cts_m <= 1'b1; cts_s <= 1'b1;
      rx_m  <= 1'b1; rx_s  <= 1'b1;
    end else begin
      cts_m <= cts_n; cts_s <= cts_m;
      rx_m  <= rxd;   rx_s  <= rx_m;
    end

  // transmitter
  tx_st_t        tx_st;
  logic [CW-1:0] tx_cnt;
  logic [2:0]    tx_idx;
  logic [7:0]    tx_sh;
  logic          tx_par;
  logic          tx_end;

  assign tx_end   = (tx_cnt == bit_last);
  assign tx_ready = (tx_st == T_IDLE) && (!fc_q || !cts_s);
  assign tx_en    = (tx_st != T_IDLE);

  always_comb
    case (tx_st)
      T_START: txd = 1'b0;
      T_DATA:  txd = tx_sh[0];
      T_PAR:   txd = tx_par;
      default: txd = 1'b1;
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_st  <= T_IDLE;
      tx_cnt <= '0;
      tx_idx <= '0;
      tx_sh  <= '0;
      tx_par <= 1'b0;
    end else if (tx_st == T_IDLE) begin
      if (tx_valid && tx_ready) begin
        tx_st  <= T_LEAD;
        tx_cnt <= '0;
        tx_sh  <= tx_data;
        tx_par <= odd_q ^ (^tx_data[6:0]) ^ (tx_data[7] & ~len7_q);
      end
    end else if (!tx_end) begin
      tx_cnt <= tx_cnt + CW'(1);
    end else begin
      tx_cnt <= '0;
      case (tx_st)
        T_LEAD:  tx_st <= T_START;
        T_START: begin tx_st <= T_DATA; tx_idx <= '0; end
        T_DATA: begin
          tx_sh  <= {1'b0, tx_sh[7:1]};
          tx_idx <= tx_idx + 3'd1;
          if (tx_idx == last_idx) begin
            tx_idx <= '0;
            tx_st  <= par_q ? T_PAR : T_STOP;
          end
        end
        T_PAR:   begin tx_st <= T_STOP; tx_idx <= '0; end
        T_STOP:
          if (stop2_q && tx_idx == 3'd0) tx_idx <= 3'd1;
          else tx_st <= T_TRAIL;
        default: tx_st <= T_IDLE;
      endcase
    end

  // receiver
  rx_st_t           rx_st;
  logic [DIV_W-1:0] rdiv;
  logic [3:0]       rsub;
  logic [2:0]       ridx;
  logic [7:0]       rsh;
  logic             rpar, rpe;
  logic             rtick, samp;

  assign rtick = (rdiv == div_eff - DIV_W'(1));
  assign samp  = rtick && (rsub == 4'd7);
  assign rts_n = fc_q & rx_valid;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_st <= R_IDLE;
      rdiv <= '0; rsub <= '0; ridx <= '0;
      rsh <= '0; rpar <= 1'b0; rpe <= 1'b0;
      rx_valid <= 1'b0; rx_data <= '0; rx_perr <= 1'b0; rx_ferr <= 1'b0;
    end else begin
      if (rx_valid && rx_ready) rx_valid <= 1'b0;
      if (rx_st == R_IDLE || rx_st == R_WAIT) begin
        rdiv <= '0;
        rsub <= '0;
      end else begin
        rdiv <= rtick ? '0 : rdiv + DIV_W'(1);
        if (rtick) rsub <= rsub + 4'd1;
      end
      case (rx_st)
        R_IDLE:
          if (!rx_s) begin
            rx_st <= R_START;
            rpe   <= 1'b0;
            rpar  <= 1'b0;
            ridx  <= '0;
          end
        R_START:
          if (samp) rx_st <= rx_s ? R_IDLE : R_DATA;
        R_DATA:
          if (samp) begin
            rsh  <= {rx_s, rsh[7:1]};
            rpar <= rpar ^ rx_s;
            ridx <= ridx + 3'd1;
            if (ridx == last_idx) rx_st <= par_q ? R_PAR : R_STOP;
          end
        R_PAR:
          if (samp) begin
            rpe   <= rpar ^ rx_s ^ odd_q;
            rx_st <= R_STOP;
          end
        R_STOP:
          if (samp) begin
            if (!rx_valid || rx_ready) begin
              rx_valid <= 1'b1;
              rx_data  <= len7_q ? {1'b0, rsh[7:1]} : rsh;
              rx_perr  <= rpe;
              rx_ferr  <= !rx_s;
            end
            rx_st <= rx_s ? R_IDLE : R_WAIT;
          end
        default:
          if (rx_s) rx_st <= R_IDLE;
      endcase
    end
endmodule

// File: rtl/uart_rs485_chk.sv
`timescale 1ns/1ps
module uart_rs485_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       txd,
  input logic       tx_en,
  input logic       tx_ready,
  input logic       fc,
  input logic       cts,
  input logic       rx_valid,
  input logic       rx_ready,
  input logic [7:0] rx_data,
  input logic       rts_n
);
  AST_LOW_LINE_ENABLED: assert property (@(posedge clk) disable iff (!rst_n) !txd |-> tx_en); // R4
  AST_ENABLE_LEADS_IDLE: assert property (@(posedge clk) disable iff (!rst_n) $rose(tx_en) |-> txd); // R4
  AST_READY_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n) tx_ready |-> !tx_en); // R5
  AST_CTS_HOLDS_OFF: assert property (@(posedge clk) disable iff (!rst_n) fc && cts && !tx_en |=> !tx_en); // R6
  AST_RTS_ON_FULL: assert property (@(posedge clk) disable iff (!rst_n) fc && rx_valid |-> rts_n); // R7
  AST_RTS_QUIET_NO_FC: assert property (@(posedge clk) disable iff (!rst_n) !fc |-> !rts_n); // R7
  AST_RX_HELD: assert property (@(posedge clk) disable iff (!rst_n) rx_valid && !rx_ready |=> rx_valid && $stable(rx_data)); // R8
endmodule

bind uart_rs485 uart_rs485_chk u_chk (
  .clk(clk), .rst_n(rst_n), .txd(txd), .tx_en(tx_en), .tx_ready(tx_ready),
  .fc(fc_q), .cts(cts_s), .rx_valid(rx_valid), .rx_ready(rx_ready),
  .rx_data(rx_data), .rts_n(rts_n)
);

// File: tb/uart_rs485_test.sv
`timescale 1ns/1ps
module uart_rs485_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_wr = 1'b0;
  logic [15:0] cfg_div = '0;
  logic cfg_len7 = 0, cfg_par_en = 0, cfg_par_odd = 0, cfg_stop2 = 0, cfg_fc_en = 0;
  logic tx_valid = 0, rx_ready = 0, cts_n = 0, rxd_drv = 1, loop = 0;
  logic [7:0] tx_data = '0;
  logic tx_ready, rx_valid, rx_perr, rx_ferr, txd, rts_n, tx_en, rxd;
  logic [7:0] rx_data;

  assign rxd = loop ? txd : rxd_drv;
  always #10 clk = ~clk;

  uart_rs485 uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_div(cfg_div), .cfg_len7(cfg_len7),
    .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd), .cfg_stop2(cfg_stop2),
    .cfg_fc_en(cfg_fc_en), .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_perr(rx_perr), .rx_ferr(rx_ferr),
    .rx_ready(rx_ready), .txd(txd), .rxd(rxd), .rts_n(rts_n), .cts_n(cts_n), .tx_en(tx_en)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  int m_div = 326;
  bit m_len7 = 0, m_par = 0, m_odd = 0, m_stop2 = 0, m_fc = 1;
  int mq[$];
  int mcnt = 0;
  logic hs_seen = 0;
  logic [7:0] hs_data;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push_frame(input logic [7:0] d);
    int n;
    bit p;
    n = m_len7 ? 7 : 8;
    p = m_odd;
    mq.push_back(1);
    mq.push_back(0);
    for (int i = 0; i < n; i++) begin
      mq.push_back(int'(d[i]));
      p ^= d[i];
    end
    if (m_par) mq.push_back(int'(p));
    mq.push_back(1);
    if (m_stop2) mq.push_back(1);
    mq.push_back(1);
  endtask

  always @(posedge clk) begin
    hs_seen <= tx_valid && tx_ready;
    hs_data <= tx_data;
  end

  // per-clock behavioural model of line, driver enable and request line
  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      if (hs_seen) push_frame(hs_data);
      if (mq.size() > 0) begin
        check(tx_en === 1'b1 && txd === mq[0][0], "R1/R2/R4 line per clock", {tx_en, txd}, {1'b1, mq[0][0]});
        mcnt++;
        if (mcnt == m_div * 16) begin
          void'(mq.pop_front());
          mcnt = 0;
        end
      end else begin
        check(tx_en === 1'b0 && txd === 1'b1, "R4 idle line per clock", {tx_en, txd}, 2'b01);
      end
      check(rts_n === (m_fc && rx_valid), "R7 rts_n per clock", rts_n, m_fc && rx_valid);
    end
  end

  task automatic cfg(input int div, input bit len7, input bit par, input bit odd, input bit stop2, input bit fc);
    @(negedge clk);
    cfg_div = 16'(div); cfg_len7 = len7; cfg_par_en = par; cfg_par_odd = odd;
    cfg_stop2 = stop2; cfg_fc_en = fc; cfg_wr = 1;
    @(negedge clk);
    cfg_wr = 0;
    m_div = div; m_len7 = len7; m_par = par; m_odd = odd; m_stop2 = stop2; m_fc = fc;
  endtask

  task automatic send_tx(input logic [7:0] d);
    tx_valid = 1; tx_data = d;
    do @(negedge clk); while (!hs_seen);
    tx_valid = 0;
  endtask

  task automatic wait_tx_done();
    do @(negedge clk); while (mq.size() != 0 || tx_en);
    repeat (3) @(negedge clk);
  endtask

  task automatic measure_en(input logic [7:0] d, input int exp_cycles, input string tag);
    int c = 0;
    send_tx(d);
    while (tx_en) begin
      c++;
      @(negedge clk);
    end
    check(c == exp_cycles, tag, c, exp_cycles);
    wait_tx_done();
  endtask

  task automatic send_rx(input logic [7:0] d, input bit len7, input bit par, input bit odd,
                         input bit bad_par, input int nstop, input bit stopv);
    int bl = m_div * 16;
    bit p = odd ^ bad_par;
    rxd_drv = 0;
    repeat (bl) @(negedge clk);
    for (int i = 0; i < (len7 ? 7 : 8); i++) begin
      rxd_drv = d[i]; p ^= d[i];
      repeat (bl) @(negedge clk);
    end
    if (par) begin
      rxd_drv = p;
      repeat (bl) @(negedge clk);
    end
    for (int s = 0; s < nstop; s++) begin
      rxd_drv = (s == 0) ? stopv : 1'b1;
      repeat (bl) @(negedge clk);
    end
    rxd_drv = 1;
    repeat (4) @(negedge clk);
  endtask

  task automatic take();
    @(negedge clk); rx_ready = 1;
    @(negedge clk); rx_ready = 0;
    #2;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #2;
    check(tx_en === 0 && txd === 1, "R11 reset line idle", {tx_en, txd}, 2'b01);
    check(rx_valid === 0 && rts_n === 0, "R11 reset receive empty", {rx_valid, rts_n}, 0);
    repeat (3) @(negedge clk); #2;
    check(tx_ready === 1, "R5 ready after reset", tx_ready, 1);
    cts_n = 1;
    repeat (5) @(negedge clk); #2;
    check(tx_ready === 0, "R11 flow control on by default", tx_ready, 0);
    cts_n = 0;
    repeat (5) @(negedge clk);
    // default 9600 8N1 frame: 12 periods of 5216 clocks
    measure_en(8'hA5, 12 * 326 * 16, "R11 default frame length");

    cfg(2, 0, 0, 0, 0, 1);
    send_tx(8'h3C);
    #2 check(tx_ready === 0, "R5 busy not ready", tx_ready, 0);
    send_tx(8'h81);
    wait_tx_done();
    #2 check(tx_ready === 1, "R5 ready when idle", tx_ready, 1);
    measure_en(8'h5A, 12 * 32, "R4 enable span 8N1");

    cfg(2, 1, 1, 0, 1, 1);
    measure_en(8'h55, 13 * 32, "R4 enable span 7E2");
    send_tx(8'h7F);
    wait_tx_done();
    cfg(3, 0, 1, 1, 0, 1);
    send_tx(8'h00);
    send_tx(8'hFF);
    wait_tx_done();

    // CTS raised mid-frame: frame completes, next waits
    cfg(2, 0, 0, 0, 0, 1);
    send_tx(8'h96);
    repeat (50) @(negedge clk);
    cts_n = 1;
    tx_valid = 1; tx_data = 8'h69;
    do @(negedge clk); while (tx_en);
    repeat (100) @(negedge clk);
    #2;
    check(tx_en === 0 && tx_ready === 0, "R6 no start while cts_n high", {tx_en, tx_ready}, 0);
    cts_n = 0;
    do @(negedge clk); while (!hs_seen);
    tx_valid = 0;
    wait_tx_done();

    cfg(2, 0, 0, 0, 0, 0);
    cts_n = 1;
    repeat (4) @(negedge clk); #2;
    check(tx_ready === 1, "R6 cts_n ignored without flow control", tx_ready, 1);
    send_tx(8'h42);
    wait_tx_done();
    cts_n = 0;

    // receive path
    cfg(2, 0, 0, 0, 0, 1);
    send_rx(8'hC3, 0, 0, 0, 0, 1, 1);
    check(rx_valid === 1 && rx_data === 8'hC3, "R2 receive 8N1 lsb first", {rx_valid, rx_data}, {1'b1, 8'hC3});
    check(rx_perr === 0 && rx_ferr === 0, "R8 clean byte flags", {rx_perr, rx_ferr}, 0);
    check(rts_n === 1, "R7 rts_n high while full", rts_n, 1);
    send_rx(8'h11, 0, 0, 0, 0, 1, 1);
    check(rx_valid === 1 && rx_data === 8'hC3, "R8 full register keeps first byte", rx_data, 8'hC3);
    take();
    check(rx_valid === 0 && rts_n === 0, "R8 byte taken", {rx_valid, rts_n}, 0);

    cfg(2, 1, 1, 1, 0, 1);
    send_rx(8'h2A, 1, 1, 1, 0, 1, 1);
    check(rx_valid === 1 && rx_data === 8'h2A && rx_perr === 0, "R3 odd parity good", {rx_data, rx_perr}, {8'h2A, 1'b0});
    take();
    send_rx(8'hAB, 1, 1, 1, 1, 1, 1);
    check(rx_data === 8'h2B, "R2 seven-bit receive clears bit 7", rx_data, 8'h2B);
    check(rx_perr === 1 && rx_ferr === 0, "R3 odd parity fault", {rx_perr, rx_ferr}, 2'b10);
    take();
    cfg(2, 0, 1, 0, 0, 1);
    send_rx(8'h07, 0, 1, 0, 1, 1, 1);
    check(rx_perr === 1, "R3 even parity fault", rx_perr, 1);
    take();

    cfg(2, 0, 0, 0, 0, 1);
    send_rx(8'hE4, 0, 0, 0, 0, 1, 0);
    check(rx_valid === 1 && rx_ferr === 1 && rx_data === 8'hE4, "R10 framing fault", {rx_ferr, rx_data}, {1'b1, 8'hE4});
    take();
    repeat (200) @(negedge clk); #2;
    check(rx_valid === 0, "R10 no phantom byte after low stop", rx_valid, 0);

    rxd_drv = 0;
    repeat (6) @(negedge clk);
    rxd_drv = 1;
    repeat (300) @(negedge clk); #2;
    check(rx_valid === 0, "R9 glitch rejected", rx_valid, 0);

    cfg(2, 0, 0, 0, 0, 0);
    send_rx(8'h3E, 0, 0, 0, 0, 1, 1);
    check(rx_valid === 1 && rts_n === 0, "R7 rts_n low without flow control", {rx_valid, rts_n}, 2'b10);
    take();

    cfg(3, 0, 1, 0, 1, 1);
    loop = 1;
    send_tx(8'h9D);
    wait_tx_done();
    #2;
    check(rx_valid === 1 && rx_data === 8'h9D && rx_perr === 0 && rx_ferr === 0,
          "R1/R3 loopback 8E2", {rx_valid, rx_perr, rx_ferr, rx_data}, {3'b100, 8'h9D});
    take();
    loop = 0;

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 190000, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule